// File: doc/BRIEF.md
# Ping-Pong Buffer Select Controller

This block steers a streaming endpoint that shuttles data between a parallel storage-drive port and a USB engine through two alternating 512-byte buffers, called A and B. It holds the transfer direction, the currently loaded buffer and a byte count for each buffer. The data path pulses a strobe for every byte it stores, and the block counts that byte into the buffer that is selected. Software selects a buffer through a control register. The select field in that register only takes effect when a qualifier bit is set in the same write. Selecting a buffer empties that buffer's count.

In auto-alternate mode the hardware changes buffers by itself. It switches when the active buffer fills up or when the data path signals the end of a transfer, and it empties the count of the buffer it switches to. The select field then reads back the buffer being loaded. The block also watches the token type the USB engine reports. A token that runs against the programmed direction raises a sticky error flag, and software clears that flag by writing one to it.

Top module: `ppbuf_ctrl`

## Requirements
- R1: After reset, buffer A is selected (buf_sel=0), direction is 0, auto-alternate is off, the error flag is 0 and both counts are 0.
- R2: A write to the control register (address 0) with bit 2 (select-qualifier) set to 1 loads bit 1 into the select (0=A, 1=B) and clears the selected buffer's count. The other buffer's count is kept.
- R3: A control write with bit 2 set to 0 leaves the select and both counts unchanged. Bit 0 (direction) and bit 3 (auto-alternate enable) are still written.
- R4: Reading address 0 returns direction in bit 0, the current select in bit 1, auto-alternate enable in bit 3, and 0 in bit 2 and in all other bits.
- R5: Each byte strobe adds one to the count of the selected buffer only.
- R6: A count stops at 512. With auto-alternate off, further byte strobes leave it at 512 and do not change the select.
- R7: With auto-alternate on, the byte strobe that brings the active count to 512 switches the select to the other buffer and clears that buffer's count. The filled buffer keeps 512.
- R8: With auto-alternate on, an end-of-transfer strobe switches buffers and clears the new buffer's count. With auto-alternate off, the strobe has no effect.
- R9: With direction 1 (drive toward USB), an OUT token sets the error flag and an IN token does not.
- R10: With direction 0, an IN token sets the error flag and an OUT token does not.
- R11: The error flag (address 1, bit 0) stays set until a write of 1 to that bit clears it. A write of 0 has no effect. A wrong-direction token in the same cycle as a clear leaves the flag set.
- R12: When a select-qualified control write and a byte strobe fall in the same cycle, the write takes effect and the byte is not counted in either buffer.
- R13: Addresses 2 and 3 return bits 7:0 and the upper bits of the A count. Addresses 4 and 5 return the same for the B count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| byte_wr | input | 1 | One byte stored into the active buffer |
| xfer_end | input | 1 | End-of-transfer strobe from the data path |
| tok_in | input | 1 | IN token received for this endpoint |
| tok_out | input | 1 | OUT token received for this endpoint |
| buf_sel | output | 1 | Active buffer, 0=A, 1=B |
| dir | output | 1 | Programmed direction |
| ep_err | output | 1 | Sticky wrong-direction error flag |
| cnt_a | output | 10 | Byte count of buffer A |
| cnt_b | output | 10 | Byte count of buffer B |

## Verification
The bench targets the 511th and 512th byte. A design that compares the count against the wrong value switches one byte early or late, or leaves the filled buffer at 511. It writes the select without its qualifier and re-selects an already active buffer. A design that ignores the qualifier moves the select, and one that only clears on a real change leaves a stale count. It also drives an end-of-transfer strobe with auto-alternate off, a byte strobe in the same cycle as a select write, and a wrong-direction token in the same cycle as an error clear. Each of these shows up as a wrong count, select or flag when the write priority is wrong.

// File: rtl/ppbuf_pkg.sv
package ppbuf_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT    = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CNTA_LO = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CNTA_HI = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CNTB_LO = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_CNTB_HI = 3'd5;

  localparam int BIT_DIR    = 0;
  localparam int BIT_SEL    = 1;
  localparam int BIT_SELVLD = 2;
  localparam int BIT_AUTO   = 3;
  localparam int BIT_ERR    = 0;

  localparam int NUM_BUF = 2;

  typedef struct packed {
    logic dir;
    logic auto_en;
  } ctrl_t;
endpackage

// File: rtl/ppbuf_regs.sv
module ppbuf_regs
  import ppbuf_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cur_sel,
  input  logic              err_q,
  input  logic [CNT_W-1:0]  cnt_a,
  input  logic [CNT_W-1:0]  cnt_b,
  output ctrl_t             ctrl_o,
  output logic              sel_wr_req,
  output logic              sel_wr_val,
  output logic              err_clr
);
  ctrl_t ctrl_q, ctrl_d;
  logic  ctrl_wr;
  logic  unused_wdata;

  assign ctrl_wr    = reg_we && (reg_addr == ADR_CTRL);
  assign sel_wr_req = ctrl_wr && reg_wdata[BIT_SELVLD];
  assign sel_wr_val = reg_wdata[BIT_SEL];
  assign err_clr    = reg_we && (reg_addr == ADR_STAT) && reg_wdata[BIT_ERR];
  assign unused_wdata = ^reg_wdata[DATA_W-1:BIT_AUTO+1];

  always_comb begin
    ctrl_d         = ctrl_q;
    ctrl_d.dir     = reg_wdata[BIT_DIR];
    ctrl_d.auto_en = reg_wdata[BIT_AUTO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl_o = ctrl_q;

  function automatic logic [DATA_W-1:0] cnt_byte(input logic [CNT_W-1:0] c,
                                                 input logic hi);
    logic [15:0] ext;
    ext = 16'(c);
    return hi ? ext[15:8] : ext[7:0];
  endfunction

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_CTRL: begin
        reg_rdata[BIT_DIR]  = ctrl_q.dir;
        reg_rdata[BIT_SEL]  = cur_sel;
        reg_rdata[BIT_AUTO] = ctrl_q.auto_en;
      end
      ADR_STAT:    reg_rdata[BIT_ERR] = err_q;
      ADR_CNTA_LO: reg_rdata = cnt_byte(cnt_a, 1'b0);
      ADR_CNTA_HI: reg_rdata = cnt_byte(cnt_a, 1'b1);
      ADR_CNTB_LO: reg_rdata = cnt_byte(cnt_b, 1'b0);
      ADR_CNTB_HI: reg_rdata = cnt_byte(cnt_b, 1'b1);
      default:     reg_rdata = '0;
    endcase
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_q)) else $error("ctrl changed without write"); // R3
endmodule

// File: rtl/ppbuf_cnt.sv
module ppbuf_cnt #(
  parameter int BUF_BYTES = 512,
  parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BUF_BYTES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i || (inc_i && (cnt_q != FULL));
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL) else $error("count above buffer size"); // R6
  AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0)) else $error("count not cleared"); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && (cnt_q < FULL)) |=> (cnt_q == $past(cnt_q) + 1'b1))
    else $error("count did not step"); // R5
endmodule

// File: rtl/ppbuf_sel.sv
module ppbuf_sel
  import ppbuf_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               auto_en,
  input  logic               sel_wr_req,
  input  logic               sel_wr_val,
  input  logic               byte_wr,
  input  logic               xfer_end,
  input  logic [CNT_W-1:0]   cnt_a,
  input  logic [CNT_W-1:0]   cnt_b,
  output logic               sel_o,
  output logic [NUM_BUF-1:0] clr_o,
  output logic [NUM_BUF-1:0] inc_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BUF_BYTES - 1);

  logic             sel_q, sel_d, sel_en;
  logic [CNT_W-1:0] act_cnt;
  logic             fill_done, hw_tog;

  always_comb begin
    act_cnt   = sel_q ? cnt_b : cnt_a;
    fill_done = byte_wr && (act_cnt >= LAST);
    hw_tog    = auto_en && !sel_wr_req && (fill_done || xfer_end);
    sel_en    = sel_wr_req || hw_tog;
    sel_d     = sel_wr_req ? sel_wr_val : ~sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  for (genvar gi = 0; gi < NUM_BUF; gi++) begin : g_bufctl
    assign clr_o[gi] = (sel_wr_req && (sel_wr_val == 1'(gi))) ||
                       (hw_tog && (sel_q != 1'(gi)));
    assign inc_o[gi] = byte_wr && !sel_wr_req && (sel_q == 1'(gi));
  end

  assign sel_o = sel_q;

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_wr_req && !auto_en) |=> $stable(sel_q)) else $error("select moved"); // R3
  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr_req |=> (sel_q == $past(sel_wr_val))) else $error("select not loaded"); // R2
  AST_ONE_INC: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inc_o)) else $error("two buffers counted"); // R5
endmodule

// File: rtl/ppbuf_err.sv
module ppbuf_err (
  input  logic clk,
  input  logic rst_n,
  input  logic dir,
  input  logic tok_in,
  input  logic tok_out,
  input  logic err_clr,
  output logic err_o
);
  logic err_q, err_d, err_en, bad_tok;

  always_comb begin
    bad_tok = dir ? tok_out : tok_in;
    err_en  = bad_tok || err_clr;
    err_d   = bad_tok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  assign err_o = err_q;

  AST_ERR_OUT_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (dir && tok_out) |=> err_q) else $error("OUT token missed"); // R9
  AST_ERR_IN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir && tok_in) |=> err_q) else $error("IN token missed"); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q) else $error("flag dropped"); // R11
endmodule

// File: rtl/ppbuf_ctrl.sv
module ppbuf_ctrl
  import ppbuf_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              byte_wr,
  input  logic              xfer_end,
  input  logic              tok_in,
  input  logic              tok_out,
  output logic              buf_sel,
  output logic              dir,
  output logic              ep_err,
  output logic [CNT_W-1:0]  cnt_a,
  output logic [CNT_W-1:0]  cnt_b
);
  logic [1:0]         rst_pipe;
  logic               rst_n_s;
  ctrl_t              ctrl;
  logic               sel_wr_req, sel_wr_val, err_clr;
  logic [NUM_BUF-1:0] clr_v, inc_v;
  logic [CNT_W-1:0]   cnt_v [NUM_BUF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  ppbuf_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .cur_sel    (buf_sel),
    .err_q      (ep_err),
    .cnt_a      (cnt_v[0]),
    .cnt_b      (cnt_v[1]),
    .ctrl_o     (ctrl),
    .sel_wr_req (sel_wr_req),
    .sel_wr_val (sel_wr_val),
    .err_clr    (err_clr)
  );

  ppbuf_sel #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .auto_en    (ctrl.auto_en),
    .sel_wr_req (sel_wr_req),
    .sel_wr_val (sel_wr_val),
    .byte_wr    (byte_wr),
    .xfer_end   (xfer_end),
    .cnt_a      (cnt_v[0]),
    .cnt_b      (cnt_v[1]),
    .sel_o      (buf_sel),
    .clr_o      (clr_v),
    .inc_o      (inc_v)
  );

  for (genvar gi = 0; gi < NUM_BUF; gi++) begin : g_cnt
    ppbuf_cnt #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n_s),
      .clr_i (clr_v[gi]),
      .inc_i (inc_v[gi]),
      .cnt_o (cnt_v[gi])
    );
  end

  ppbuf_err u_err (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .dir     (ctrl.dir),
    .tok_in  (tok_in),
    .tok_out (tok_out),
    .err_clr (err_clr),
    .err_o   (ep_err)
  );

  assign dir   = ctrl.dir;
  assign cnt_a = cnt_v[0];
  assign cnt_b = cnt_v[1];

  AST_SWITCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (buf_sel != $past(buf_sel)) |-> (cnt_v[buf_sel] == '0))
    else $error("new buffer not empty"); // R7
endmodule

// File: tb/tb_ppbuf_ctrl.sv
`timescale 1ns/1ps
module tb_ppbuf_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       byte_wr, xfer_end, tok_in, tok_out;
  logic       buf_sel, dir, ep_err;
  logic [9:0] cnt_a, cnt_b;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  ppbuf_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .byte_wr(byte_wr),
    .xfer_end(xfer_end), .tok_in(tok_in), .tok_out(tok_out),
    .buf_sel(buf_sel), .dir(dir), .ep_err(ep_err), .cnt_a(cnt_a), .cnt_b(cnt_b)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic bytes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_wr = 1'b1;
    end
    @(negedge clk);
    byte_wr = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk); xfer_end = 1'b1;
    @(negedge clk); xfer_end = 1'b0;
  endtask

  task automatic pulse_tok(input logic is_in);
    @(negedge clk); tok_in = is_in; tok_out = !is_in;
    @(negedge clk); tok_in = 1'b0; tok_out = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    chk("R1 sel", buf_sel, 0);
    chk("R1 dir", dir, 0);
    chk("R1 err", ep_err, 0);
    chk("R1 cnt_a", cnt_a, 0);
    chk("R1 cnt_b", cnt_b, 0);
    rd(3'd0, v); chk("R1 ctrl read", v, 0);
  endtask

  task automatic t_manual();
    int v;
    bytes(5);
    chk("R5 cnt_a", cnt_a, 5); chk("R5 cnt_b", cnt_b, 0);
    wr(3'd0, 8'h06);
    chk("R2 sel B", buf_sel, 1); chk("R2 cnt_a kept", cnt_a, 5); chk("R2 cnt_b", cnt_b, 0);
    bytes(3);
    chk("R5 cnt_b", cnt_b, 3); chk("R5 cnt_a", cnt_a, 5);
    wr(3'd0, 8'h06);
    chk("R2 reselect clears", cnt_b, 0);
    wr(3'd0, 8'h01);
    chk("R3 sel kept", buf_sel, 1); chk("R3 dir written", dir, 1);
    chk("R3 cnt_a kept", cnt_a, 5);
    rd(3'd0, v); chk("R4 ctrl read", v, 8'h03);
    rd(3'd2, v); chk("R13 A lo", v, 5);
    rd(3'd3, v); chk("R13 A hi", v, 0);
  endtask

  task automatic t_sat();
    int v;
    wr(3'd0, 8'h04);
    chk("R2 sel A", buf_sel, 0); chk("R2 cnt_a cleared", cnt_a, 0);
    bytes(520);
    chk("R6 cnt_a sat", cnt_a, 512); chk("R6 sel kept", buf_sel, 0);
    rd(3'd3, v); chk("R13 A hi", v, 2);
    rd(3'd2, v); chk("R13 A lo", v, 0);
  endtask

  task automatic t_auto();
    int v;
    wr(3'd0, 8'h0C);
    chk("R2 cnt_a cleared", cnt_a, 0);
    bytes(511);
    chk("R7 at 511 sel", buf_sel, 0); chk("R7 cnt_a 511", cnt_a, 511);
    bytes(1);
    chk("R7 switched", buf_sel, 1); chk("R7 cnt_a full", cnt_a, 512);
    chk("R7 cnt_b new", cnt_b, 0);
    bytes(10);
    chk("R7 cnt_b", cnt_b, 10);
    rd(3'd0, v); chk("R4 ctrl auto read", v, 8'h0A);
    pulse_end();
    chk("R8 end switch", buf_sel, 0); chk("R8 cnt_a cleared", cnt_a, 0);
    chk("R8 cnt_b kept", cnt_b, 10);
    rd(3'd4, v); chk("R13 B lo", v, 10);
    rd(3'd5, v); chk("R13 B hi", v, 0);
  endtask

  task automatic t_manual_end();
    wr(3'd0, 8'h06);
    bytes(4);
    pulse_end();
    chk("R8 manual end sel", buf_sel, 1); chk("R8 manual cnt_b", cnt_b, 4);
    chk("R8 manual cnt_a", cnt_a, 0);
  endtask

  task automatic t_collide();
    wr(3'd0, 8'h04);
    bytes(2);
    chk("R5 cnt_a", cnt_a, 2);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h06; byte_wr = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; byte_wr = 1'b0;
    chk("R12 sel", buf_sel, 1); chk("R12 cnt_b", cnt_b, 0); chk("R12 cnt_a", cnt_a, 2);
  endtask

  task automatic t_err();
    int v;
    wr(3'd0, 8'h01);
    pulse_tok(1'b1); chk("R9 IN ok", ep_err, 0);
    pulse_tok(1'b0); chk("R9 OUT err", ep_err, 1);
    rd(3'd1, v); chk("R11 status read", v, 1);
    wr(3'd1, 8'h00); chk("R11 write 0", ep_err, 1);
    wr(3'd1, 8'h01); chk("R11 clear", ep_err, 0);
    wr(3'd0, 8'h00);
    pulse_tok(1'b0); chk("R10 OUT ok", ep_err, 0);
    pulse_tok(1'b1); chk("R10 IN err", ep_err, 1);
    wr(3'd1, 8'h01); chk("R11 clear", ep_err, 0);
    pulse_tok(1'b1);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h01; tok_in = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; tok_in = 1'b0;
    chk("R11 set beats clear", ep_err, 1);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    byte_wr = 1'b0; xfer_end = 1'b0; tok_in = 1'b0; tok_out = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_manual();
    t_sat();
    t_auto();
    t_manual_end();
    t_collide();
    t_err();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule